// File: doc/BRIEF.md
# Processor Mode and Status Controller

This block keeps the live program status word of a processor core. The word holds the four arithmetic flags, two interrupt-disable bits, an instruction-state bit and a five-bit mode field. The block also keeps one saved status word for each of the five exception modes. Six exception request lines enter the block. Each cycle it chooses one winner by fixed priority. IRQ is dropped while its disable bit is set, and FIQ is dropped while its disable bit is set. The block then moves to the winner's mode, saves the old status in that mode's bank and raises the interrupt-disable bits.

Software changes the live word through a status-write port. In any privileged mode, software can also write the saved copy of the current mode and then issue an exception return. The return restores the mode and all the flags on a single clock edge. User mode can only change the arithmetic flags. System mode is never entered by an exception: the only way in is an explicit write of its encoding.

Top module: `psr_ctrl`

## Requirements
- R1: After reset, the status word is 0x000000D3 (supervisor mode, both interrupt-disable bits set, state bit clear, flags clear). Every saved bank holds that same value. `exc_taken` is 0.
- R2: Layout of the status word. N, Z, C and V sit at bits 31, 30, 29 and 28. The IRQ disable bit is bit 7, the FIQ disable bit is bit 6, the state bit is bit 5 and the mode is bits 4:0. Every other bit always reads 0, and writing those bits has no effect.
- R3: Each exception has a target mode and a code on `exc_code`. Reset: supervisor 10011, code 1. Abort: 10111, code 2. FIQ: 10001, code 3. IRQ: 10010, code 4. Undefined instruction: 11011, code 5. Software interrupt: supervisor 10011, code 6. No exception ever enters system mode 11111 or user mode 10000.
- R4: When several requests are raised together, the winner follows this order: reset, abort, FIQ, IRQ, undefined instruction, software interrupt.
- R5: An IRQ request is ignored while bit 7 is 1. An FIQ request is ignored while bit 6 is 1. The other requests are never masked.
- R6: On the clock edge that takes an exception, the following happens. The old status word is stored in the target mode's bank. Bit 7 is set and bit 5 is cleared. Bit 6 is set for FIQ and for reset, and is left unchanged for the others. The flags are kept. `exc_taken` pulses high for that cycle and shows the code.
- R7: In user mode 10000, a status write updates only bits 31:28. Bits 7:0 are kept.
- R8: In a privileged mode, a status write updates the flags and bits 7:5. It updates the mode only when the written value is one of the seven legal encodings; an illegal value keeps the old mode. A write is the only way to reach system mode.
- R9: A saved-status write goes to the bank of the current mode and follows the same legality rules as R8. `saved_q` shows that bank. In user and system mode the saved-status write is ignored and `saved_q` reads 0.
- R10: An exception return copies the current mode's bank into the status word on one edge. In user and system mode the return is ignored.
- R11: Precedence within one cycle: a taken exception drops any return and both writes. A return drops both writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_req | input | 1 | Reset exception request |
| abt_req | input | 1 | Memory protection fault request |
| fiq_req | input | 1 | Fast interrupt request |
| irq_req | input | 1 | Interrupt request |
| und_req | input | 1 | Invalid instruction request |
| swi_req | input | 1 | Software interrupt request |
| ret_en | input | 1 | Exception-return command |
| cur_wr_en | input | 1 | Status word write strobe |
| cur_wr_data | input | PSR_W | Status word write value |
| sav_wr_en | input | 1 | Saved-status write strobe for the current mode |
| sav_wr_data | input | PSR_W | Saved-status write value |
| psr_q | output | PSR_W | Live status word |
| saved_q | output | PSR_W | Saved status of the current mode, 0 if the mode has no bank |
| exc_taken | output | 1 | Pulse: an exception was taken on the last edge |
| exc_code | output | 3 | Code of the exception that was taken |

## Verification
A wrong bank index or a bad save on entry stays hidden at first. It shows on `psr_q` on the edge after the later return, or at once on `saved_q` once the core is in that mode. A bad priority or masking decision shows on the next edge as the wrong mode on `psr_q` and the wrong code on `exc_code`. Because of this, the bench compares the whole port state against its own model after every cycle. It also runs long random sequences of entries and returns, so that a corrupted bank is eventually read back.

// File: rtl/psr_pkg.sv
package psr_pkg;

   typedef enum logic [4:0] {
      M_USR = 5'b10000,
      M_FIQ = 5'b10001,
      M_IRQ = 5'b10010,
      M_SVC = 5'b10011,
      M_ABT = 5'b10111,
      M_UND = 5'b11011,
      M_SYS = 5'b11111
   } mode_e;

   typedef enum logic [2:0] {
      EXC_NONE = 3'd0,
      EXC_RST  = 3'd1,
      EXC_ABT  = 3'd2,
      EXC_FIQ  = 3'd3,
      EXC_IRQ  = 3'd4,
      EXC_UND  = 3'd5,
      EXC_SWI  = 3'd6
   } exc_e;

   localparam int MODE_W     = 5;
   localparam int BIT_T      = 5;
   localparam int BIT_F      = 6;
   localparam int BIT_I      = 7;
   localparam int CTRL_W     = 8;
   localparam int NUM_BANKS  = 5;
   localparam int BANK_IDX_W = $clog2(NUM_BANKS);
   localparam int NUM_REQ    = 6;
   localparam int CODE_W     = 3;

   function automatic logic mode_legal(input logic [MODE_W-1:0] m);
      case (m)
         M_USR, M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND, M_SYS: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic mode_banked(input logic [MODE_W-1:0] m);
      case (m)
         M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [BANK_IDX_W-1:0] bank_of(input logic [MODE_W-1:0] m);
      case (m)
         M_FIQ:   return BANK_IDX_W'(0);
         M_IRQ:   return BANK_IDX_W'(1);
         M_SVC:   return BANK_IDX_W'(2);
         M_ABT:   return BANK_IDX_W'(3);
         M_UND:   return BANK_IDX_W'(4);
         default: return BANK_IDX_W'(0);
      endcase
   endfunction

   function automatic logic [MODE_W-1:0] exc_target(input logic [CODE_W-1:0] c);
      case (c)
         EXC_ABT: return M_ABT;
         EXC_FIQ: return M_FIQ;
         EXC_IRQ: return M_IRQ;
         EXC_UND: return M_UND;
         default: return M_SVC;
      endcase
   endfunction

endpackage

// File: rtl/psr_exc_arb.sv
module psr_exc_arb
   import psr_pkg::*;
(
   input  logic              rst_req,
   input  logic              abt_req,
   input  logic              fiq_req,
   input  logic              irq_req,
   input  logic              und_req,
   input  logic              swi_req,
   input  logic              i_dis,
   input  logic              f_dis,
   output logic              take,
   output logic [CODE_W-1:0] code,
   output logic [MODE_W-1:0] target,
   output logic              set_f
);

   localparam int WIN_W = $clog2(NUM_REQ);

   // index 0 is the highest priority; index + 1 is the exception code
   logic [NUM_REQ-1:0] req_vec;
   logic [WIN_W-1:0]   win_idx;
   logic               found;

   assign req_vec = {swi_req, und_req, irq_req & ~i_dis,
                     fiq_req & ~f_dis, abt_req, rst_req};

   always_comb begin
      found   = 1'b0;
      win_idx = '0;
      for (int i = 0; i < NUM_REQ; i++) begin
         if (!found && req_vec[i]) begin
            found   = 1'b1;
            win_idx = WIN_W'(i);
         end
      end
   end

   assign take   = found;
   assign code   = found ? (CODE_W'(win_idx) + CODE_W'(1)) : CODE_W'(EXC_NONE);
   assign target = exc_target(code);
   assign set_f  = found && (code == EXC_FIQ || code == EXC_RST);

endmodule

// File: rtl/psr_wr_legal.sv
module psr_wr_legal
   import psr_pkg::*;
#(
   parameter int PSR_W    = 32,
   parameter int FLAG_LSB = 28
) (
   input  logic [CTRL_W-1:0] old_ctrl,
   input  logic [PSR_W-1:0]  wr_val,
   input  logic              allow_ctrl,
   output logic [PSR_W-1:0]  result
);

   localparam logic [PSR_W-1:0] FLAG_MASK = PSR_W'({4'hF}) << FLAG_LSB;

   logic [PSR_W-1:0]  flag_part;
   logic [CTRL_W-1:0] ctrl_part;

   assign flag_part = wr_val & FLAG_MASK;

   always_comb begin
      ctrl_part = old_ctrl;
      if (allow_ctrl) begin
         ctrl_part[BIT_I] = wr_val[BIT_I];
         ctrl_part[BIT_F] = wr_val[BIT_F];
         ctrl_part[BIT_T] = wr_val[BIT_T];
         if (mode_legal(wr_val[MODE_W-1:0])) begin
            ctrl_part[MODE_W-1:0] = wr_val[MODE_W-1:0];
         end
      end
   end

   assign result = flag_part | PSR_W'(ctrl_part);

endmodule

// File: rtl/psr_bank.sv
module psr_bank
   import psr_pkg::*;
#(
   parameter int               PSR_W   = 32,
   parameter int               NUM     = NUM_BANKS,
   parameter logic [PSR_W-1:0] RST_VAL = '0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [BANK_IDX_W-1:0] wr_idx,
   input  logic [PSR_W-1:0]      wr_data,
   input  logic [BANK_IDX_W-1:0] rd_idx,
   output logic [PSR_W-1:0]      rd_data
);

   logic [PSR_W-1:0] bank_r [NUM];

   for (genvar g = 0; g < NUM; g++) begin : g_bank
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bank_r[g] <= RST_VAL;
         end else if (wr_en && wr_idx == BANK_IDX_W'(g)) begin
            bank_r[g] <= wr_data;
         end
      end

      // R9: a bank changes only on a write aimed at it
      a_r9_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
         !(wr_en && wr_idx == BANK_IDX_W'(g)) |=> $stable(bank_r[g]));
   end

   assign rd_data = (int'(rd_idx) < NUM) ? bank_r[rd_idx] : '0;

endmodule

// File: rtl/psr_ctrl.sv
module psr_ctrl
   import psr_pkg::*;
#(
   parameter int PSR_W    = 32,
   parameter int FLAG_LSB = 28
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rst_req,
   input  logic             abt_req,
   input  logic             fiq_req,
   input  logic             irq_req,
   input  logic             und_req,
   input  logic             swi_req,
   input  logic             ret_en,
   input  logic             cur_wr_en,
   input  logic [PSR_W-1:0] cur_wr_data,
   input  logic             sav_wr_en,
   input  logic [PSR_W-1:0] sav_wr_data,
   output logic [PSR_W-1:0] psr_q,
   output logic [PSR_W-1:0] saved_q,
   output logic             exc_taken,
   output logic [2:0]       exc_code
);

   localparam logic [PSR_W-1:0] PSR_RST =
      {{(PSR_W-CTRL_W){1'b0}}, 1'b1, 1'b1, 1'b0, M_SVC};

   if (PSR_W < 32) begin : g_bad_width
      $error("psr_ctrl: PSR_W must be at least 32");
   end
   if (FLAG_LSB < CTRL_W || FLAG_LSB + 4 > PSR_W) begin : g_bad_flags
      $error("psr_ctrl: flag field must lie above the control byte");
   end

   logic [PSR_W-1:0]      psr_r, psr_nxt;
   logic                  taken_r;
   logic [CODE_W-1:0]     code_r;
   logic [MODE_W-1:0]     cur_mode;
   logic                  cur_banked;
   logic                  take;
   logic [CODE_W-1:0]     take_code;
   logic [MODE_W-1:0]     take_mode;
   logic                  take_set_f;
   logic [PSR_W-1:0]      bank_rd;
   logic                  bank_we;
   logic [BANK_IDX_W-1:0] bank_widx;
   logic [PSR_W-1:0]      bank_wdata;
   logic [PSR_W-1:0]      cur_legal, sav_legal;
   logic                  do_ret;

   assign cur_mode   = psr_r[MODE_W-1:0];
   assign cur_banked = mode_banked(cur_mode);

   psr_exc_arb u_arb (
      .rst_req (rst_req),
      .abt_req (abt_req),
      .fiq_req (fiq_req),
      .irq_req (irq_req),
      .und_req (und_req),
      .swi_req (swi_req),
      .i_dis   (psr_r[BIT_I]),
      .f_dis   (psr_r[BIT_F]),
      .take    (take),
      .code    (take_code),
      .target  (take_mode),
      .set_f   (take_set_f)
   );

   psr_wr_legal #(.PSR_W(PSR_W), .FLAG_LSB(FLAG_LSB)) u_cur_legal (
      .old_ctrl   (psr_r[CTRL_W-1:0]),
      .wr_val     (cur_wr_data),
      .allow_ctrl (cur_mode != M_USR),
      .result     (cur_legal)
   );

   psr_wr_legal #(.PSR_W(PSR_W), .FLAG_LSB(FLAG_LSB)) u_sav_legal (
      .old_ctrl   (bank_rd[CTRL_W-1:0]),
      .wr_val     (sav_wr_data),
      .allow_ctrl (1'b1),
      .result     (sav_legal)
   );

   psr_bank #(.PSR_W(PSR_W), .NUM(NUM_BANKS), .RST_VAL(PSR_RST)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bank_we),
      .wr_idx  (bank_widx),
      .wr_data (bank_wdata),
      .rd_idx  (bank_of(cur_mode)),
      .rd_data (bank_rd)
   );

   assign do_ret = !take && ret_en && cur_banked;

   always_comb begin
      psr_nxt    = psr_r;
      bank_we    = 1'b0;
      bank_widx  = bank_of(cur_mode);
      bank_wdata = sav_legal;
      if (take) begin
         psr_nxt[MODE_W-1:0] = take_mode;
         psr_nxt[BIT_I]      = 1'b1;
         psr_nxt[BIT_T]      = 1'b0;
         if (take_set_f) psr_nxt[BIT_F] = 1'b1;
         bank_we    = 1'b1;
         bank_widx  = bank_of(take_mode);
         bank_wdata = psr_r;
      end else if (do_ret) begin
         psr_nxt = bank_rd;
      end else begin
         if (cur_wr_en) psr_nxt = cur_legal;
         bank_we = sav_wr_en && cur_banked;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         psr_r   <= PSR_RST;
         taken_r <= 1'b0;
         code_r  <= EXC_NONE;
      end else begin
         psr_r   <= psr_nxt;
         taken_r <= take;
         code_r  <= take_code;
      end
   end

   assign psr_q     = psr_r;
   assign saved_q   = cur_banked ? bank_rd : '0;
   assign exc_taken = taken_r;
   assign exc_code  = code_r;

   // R3: the mode after an entry matches the reported code
   a_r3_mode_matches_code: assert property (@(posedge clk) disable iff (!rst_n)
      taken_r |-> (cur_mode == exc_target(code_r)));

   // R3: exceptions never land in system or user mode
   a_r3_no_sys_entry: assert property (@(posedge clk) disable iff (!rst_n)
      taken_r |-> (cur_mode != M_SYS && cur_mode != M_USR));

   // R5: an IRQ is taken only if its disable bit was clear
   a_r5_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (taken_r && code_r == EXC_IRQ) |-> !$past(psr_r[BIT_I]));

   // R5: an FIQ is taken only if its disable bit was clear
   a_r5_fiq_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (taken_r && code_r == EXC_FIQ) |-> !$past(psr_r[BIT_F]));

   // R6: entry leaves IRQ disabled and the state bit clear
   a_r6_entry_bits: assert property (@(posedge clk) disable iff (!rst_n)
      taken_r |-> (psr_r[BIT_I] && !psr_r[BIT_T]));

   // R6: FIQ and reset entries set the FIQ disable bit
   a_r6_fiq_sets_f: assert property (@(posedge clk) disable iff (!rst_n)
      (taken_r && (code_r == EXC_FIQ || code_r == EXC_RST)) |-> psr_r[BIT_F]);

   // R7: user mode keeps its control byte unless an exception is taken
   a_r7_user_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode == M_USR && !take) |=> $stable(psr_r[CTRL_W-1:0]));

   // R10: a return loads the saved copy seen before the edge
   a_r10_return_loads: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_en && cur_banked && !take) |=> (psr_r == $past(bank_rd)));

   // R2: bits outside the flags and the control byte stay zero
   a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (psr_r[FLAG_LSB-1:CTRL_W] == '0));

endmodule

// File: tb/psr_ctrl_tb.sv
module psr_ctrl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rst_req = 1'b0, abt_req = 1'b0, fiq_req = 1'b0;
   logic        irq_req = 1'b0, und_req = 1'b0, swi_req = 1'b0;
   logic        ret_en = 1'b0, cur_wr_en = 1'b0, sav_wr_en = 1'b0;
   logic [31:0] cur_wr_data = '0, sav_wr_data = '0;
   logic [31:0] psr_q, saved_q;
   logic        exc_taken;
   logic [2:0]  exc_code;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // bench model state
   logic [31:0] m_psr;
   logic [31:0] m_bank [5];
   logic        m_taken;
   logic [2:0]  m_code;

   always #5 clk = ~clk;

   psr_ctrl dut_i (
      .clk(clk), .rst_n(rst_n),
      .rst_req(rst_req), .abt_req(abt_req), .fiq_req(fiq_req),
      .irq_req(irq_req), .und_req(und_req), .swi_req(swi_req),
      .ret_en(ret_en), .cur_wr_en(cur_wr_en), .cur_wr_data(cur_wr_data),
      .sav_wr_en(sav_wr_en), .sav_wr_data(sav_wr_data),
      .psr_q(psr_q), .saved_q(saved_q),
      .exc_taken(exc_taken), .exc_code(exc_code)
   );

   function automatic bit f_legal(logic [4:0] m);
      return m inside {5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F};
   endfunction

   function automatic int f_bidx(logic [4:0] m);
      case (m)
         5'h11: return 0;
         5'h12: return 1;
         5'h13: return 2;
         5'h17: return 3;
         5'h1B: return 4;
         default: return -1;
      endcase
   endfunction

   function automatic logic [4:0] f_target(int c);
      case (c)
         2: return 5'h17;
         3: return 5'h11;
         4: return 5'h12;
         5: return 5'h1B;
         default: return 5'h13;
      endcase
   endfunction

   function automatic logic [31:0] f_wr(logic [31:0] old, logic [31:0] d, bit allow);
      logic [31:0] r;
      r = '0;
      r[31:28] = d[31:28];
      r[7:0] = old[7:0];
      if (allow) begin
         r[7:5] = d[7:5];
         if (f_legal(d[4:0])) r[4:0] = d[4:0];
      end
      return r;
   endfunction

   task automatic model_reset();
      m_psr = 32'h0000_00D3;
      for (int i = 0; i < 5; i++) m_bank[i] = 32'h0000_00D3;
      m_taken = 1'b0;
      m_code = 3'd0;
   endtask

   task automatic model_step();
      int c;
      int idx;
      int t;
      c = 0;
      if (rst_req) c = 1;
      else if (abt_req) c = 2;
      else if (fiq_req && !m_psr[6]) c = 3;
      else if (irq_req && !m_psr[7]) c = 4;
      else if (und_req) c = 5;
      else if (swi_req) c = 6;
      idx = f_bidx(m_psr[4:0]);
      if (c != 0) begin
         t = f_bidx(f_target(c));
         m_bank[t] = m_psr;
         m_psr[4:0] = f_target(c);
         m_psr[7] = 1'b1;
         m_psr[5] = 1'b0;
         if (c == 1 || c == 3) m_psr[6] = 1'b1;
      end else if (ret_en && idx >= 0) begin
         m_psr = m_bank[idx];
      end else begin
         if (sav_wr_en && idx >= 0) m_bank[idx] = f_wr(m_bank[idx], sav_wr_data, 1'b1);
         if (cur_wr_en) m_psr = f_wr(m_psr, cur_wr_data, m_psr[4:0] != 5'h10);
      end
      m_taken = (c != 0);
      m_code = 3'(c);
   endtask

   function automatic logic [31:0] m_saved();
      int idx;
      idx = f_bidx(m_psr[4:0]);
      return (idx >= 0) ? m_bank[idx] : 32'h0;
   endfunction

   task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: got %08h expected %08h", tag, what, got, exp);
      end
   endtask

   task automatic clear_in();
      rst_req = 0; abt_req = 0; fiq_req = 0; irq_req = 0; und_req = 0; swi_req = 0;
      ret_en = 0; cur_wr_en = 0; sav_wr_en = 0;
   endtask

   // inputs already driven at a falling edge; compare one edge later
   task automatic step(string tag);
      model_step();
      @(negedge clk);
      chk(tag, "psr_q", psr_q, m_psr);
      chk(tag, "saved_q", saved_q, m_saved());
      chk(tag, "exc_taken", 32'(exc_taken), 32'(m_taken));
      chk(tag, "exc_code", 32'(exc_code), 32'(m_code));
      clear_in();
   endtask

   task automatic wr_cur(logic [31:0] d, string tag);
      cur_wr_en = 1; cur_wr_data = d; step(tag);
   endtask

   function automatic logic [31:0] rnd_word();
      logic [31:0] w;
      w = $urandom;
      if (($urandom % 4) != 0) begin
         case ($urandom % 7)
            0: w[4:0] = 5'h10;
            1: w[4:0] = 5'h11;
            2: w[4:0] = 5'h12;
            3: w[4:0] = 5'h13;
            4: w[4:0] = 5'h17;
            5: w[4:0] = 5'h1B;
            default: w[4:0] = 5'h1F;
         endcase
      end
      return w;
   endfunction

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1", "psr_q reset", psr_q, 32'h0000_00D3);
      chk("R1", "saved_q reset", saved_q, 32'h0000_00D3);
      chk("R1", "exc_taken reset", 32'(exc_taken), 32'h0);

      // R2 / R8: all-ones write reaches system mode, reserved bits stay 0
      wr_cur(32'hFFFF_FFFF, "R8");
      chk("R2", "reserved bits", psr_q, 32'hF000_00FF);
      chk("R9", "saved_q in system", saved_q, 32'h0);
      sav_wr_en = 1; sav_wr_data = 32'hA000_0013; step("R9");
      ret_en = 1; step("R10");
      chk("R10", "return ignored in system", psr_q, 32'hF000_00FF);

      wr_cur(32'h0000_0010, "R8");
      wr_cur(32'hA000_00DF, "R7");
      chk("R7", "user write flags only", psr_q, 32'hA000_0010);

      irq_req = 1; step("R3");
      chk("R6", "irq entry", psr_q, 32'hA000_0092);
      chk("R6", "irq bank", saved_q, 32'hA000_0010);
      irq_req = 1; und_req = 1; step("R5");
      chk("R5", "masked irq, und taken", 32'(exc_code), 32'd5);
      ret_en = 1; step("R10");
      chk("R10", "return to irq", psr_q, 32'hA000_0092);
      sav_wr_en = 1; sav_wr_data = 32'h5000_0013; step("R9");
      chk("R9", "saved write", saved_q, 32'h5000_0013);
      ret_en = 1; step("R10");
      wr_cur(32'h0000_0000, "R8");
      chk("R8", "illegal mode kept", psr_q, 32'h0000_0013);
      rst_req = 1; abt_req = 1; fiq_req = 1; irq_req = 1; und_req = 1; swi_req = 1;
      step("R4");
      chk("R4", "reset wins", 32'(exc_code), 32'd1);
      wr_cur(32'h0000_0013, "R8");
      abt_req = 1; fiq_req = 1; irq_req = 1; und_req = 1; swi_req = 1; step("R4");
      chk("R4", "abort wins", 32'(exc_code), 32'd2);
      wr_cur(32'h0000_0037, "R8");
      fiq_req = 1; irq_req = 1; und_req = 1; swi_req = 1; step("R6");
      chk("R6", "fiq entry sets F, clears T", psr_q, 32'h0000_00D1);
      ret_en = 1; swi_req = 1; cur_wr_en = 1; cur_wr_data = 32'h0000_001F; step("R11");
      chk("R11", "exception beats return", 32'(exc_code), 32'd6);
      ret_en = 1; cur_wr_en = 1; cur_wr_data = 32'h0000_001F; step("R11");
      chk("R11", "return beats write", psr_q, 32'h0000_00D1);

      // random phase
      for (int n = 0; n < 4000; n++) begin
         rst_req = (($urandom % 97) == 0);
         abt_req = (($urandom % 19) == 0);
         fiq_req = (($urandom % 11) == 0);
         irq_req = (($urandom % 9) == 0);
         und_req = (($urandom % 23) == 0);
         swi_req = (($urandom % 17) == 0);
         ret_en = (($urandom % 6) == 0);
         cur_wr_en = (($urandom % 3) == 0);
         sav_wr_en = (($urandom % 4) == 0);
         cur_wr_data = rnd_word();
         sav_wr_data = rnd_word();
         step((rst_req | abt_req | fiq_req | irq_req | und_req | swi_req) ? "R4" :
              ret_en ? "R10" : "R8");
      end

      done = 1'b1;
      summary();
      $finish;
   end

endmodule